// File: doc/BRIEF.md
# Branch Decision Unit

This unit settles the control-flow outcome of three kinds of instruction whose result depends on the condition flags: a conditional branch, a counted loop branch that decrements a register and tests it, and an instruction that sets a byte on a condition. An unconditional branch is also handled, through the same path as a taken conditional branch.

Each request presents the following inputs:
- the kind of instruction, already decoded from the opcode class bits;
- the low twelve opcode bits, which carry the condition code, the short displacement and the register select;
- the N, Z, V and C flags;
- the program counter, which already points at the word after the opcode;
- the optional 16-bit extension word;
- the selected data register.

One clock later the unit returns the following, all held in output registers, together with a one-cycle `done` strobe:
- the next program counter;
- the counter write-back value, its enable and its register select;
- the byte result;
- the cycle cost of the outcome.

Instruction fetch, address calculation and register storage sit outside the unit.

Top module: `branch_decide_unit`

## Requirements
- R1: The condition code is `opcode_lo[11:8]`. Its encodings are: 0 always true; 1 always false; 2 !C&!Z; 3 C|Z; 4 !C; 5 C; 6 !Z; 7 Z; 8 !V; 9 V; 10 !N; 11 N; 12 N==V; 13 N!=V; 14 (N==V)&!Z; 15 Z|(N!=V).
- R2: For kind 0 (conditional branch) with a nonzero signed displacement in `opcode_lo[7:0]` and a true condition, `next_pc` is `cur_pc` plus the sign-extended displacement, and `cycles` is 10.
- R3: For kind 0 with a displacement byte of zero and a true condition, `next_pc` is `cur_pc` plus the sign-extended `ext_word`, and `cycles` is 10.
- R4: For kind 0 with a false condition, the outcome depends on the displacement byte. If it is nonzero, `next_pc` equals `cur_pc` and `cycles` is 8. If it is zero, `next_pc` is `cur_pc`+2 and `cycles` is 12.
- R5: For kind 1 (unconditional branch), the displacement is applied as in R2/R3 whatever the flags and condition field are, with `cycles` of 10.
- R6: For kind 2 (loop branch) with a true condition, `next_pc` is `cur_pc`+2, `cycles` is 12 and `cnt_we` stays 0.
- R7: For kind 2 with a false condition, `cnt_we` is 1 and `cnt_sel` equals `opcode_lo[2:0]`. `cnt_out` is `cnt_in` with its low 16 bits decremented and its upper bits unchanged. If the decremented low half is 0xFFFF, `next_pc` is `cur_pc`+2 and `cycles` is 14. Otherwise `next_pc` is `cur_pc` plus the sign-extended `ext_word`, and `cycles` is 10.
- R8: For kind 3 (set byte), the condition sets the result. If it holds, `set_byte` is 0xFF and `cycles` is 6. If it does not, `set_byte` is 0x00 and `cycles` is 4. In both cases `next_pc` equals `cur_pc` and `cnt_we` stays 0.
- R9: `done` and `cnt_we` are high for exactly the one cycle after the edge that samples `req_valid`. While idle, `next_pc` holds its last value.
- R10: After reset, `done`, `cnt_we`, `next_pc`, `cnt_out`, `set_byte` and `cycles` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | 0 conditional branch, 1 unconditional branch, 2 loop branch, 3 set byte |
| opcode_lo | input | 12 | Condition [11:8], displacement [7:0], register select [2:0] |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| cur_pc | input | ADDR_W | Address of the word after the opcode |
| ext_word | input | 16 | Extension word (signed displacement) |
| cnt_in | input | REG_W | Selected data register |
| done | output | 1 | One-cycle result strobe |
| next_pc | output | ADDR_W | Resolved program counter |
| cnt_out | output | REG_W | Counter write-back value |
| cnt_we | output | 1 | Counter write enable |
| cnt_sel | output | 3 | Register to write |
| set_byte | output | 8 | Byte result for set-on-condition |
| cycles | output | 5 | Cycle cost of the outcome |

## Verification
Every result of the unit is due exactly one clock after the edge that samples `req_valid`. `done` and `cnt_we` drop again one edge later, while the other outputs keep their values. The bench drives each request on a falling edge and lowers the strobe on the next falling edge. It checks the outputs there, half a period after the registering edge, and looks again one falling edge later to confirm that the strobes have cleared and `next_pc` has held.

// File: rtl/branch_pkg.sv
package branch_pkg;

    typedef enum logic [1:0] {
        KIND_BCOND   = 2'd0,
        KIND_BALWAYS = 2'd1,
        KIND_LOOP    = 2'd2,
        KIND_SETB    = 2'd3
    } br_kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    localparam int CYC_W = 5;
    localparam logic [CYC_W-1:0] CYC_TAKEN      = 5'd10;
    localparam logic [CYC_W-1:0] CYC_SKIP_SHORT = 5'd8;
    localparam logic [CYC_W-1:0] CYC_SKIP_LONG  = 5'd12;
    localparam logic [CYC_W-1:0] CYC_LOOP_HIT   = 5'd12;
    localparam logic [CYC_W-1:0] CYC_LOOP_WRAP  = 5'd14;
    localparam logic [CYC_W-1:0] CYC_SET_TRUE   = 5'd6;
    localparam logic [CYC_W-1:0] CYC_SET_FALSE  = 5'd4;

    // Truth of one condition code for a given flag set.
    function automatic logic cond_holds(input logic [3:0] code, input flags_t f);
        logic signed_ok;
        signed_ok = (f.n == f.v);
        case (code)
            4'd0:  return 1'b1;
            4'd1:  return 1'b0;
            4'd2:  return !f.c && !f.z;
            4'd3:  return f.c || f.z;
            4'd4:  return !f.c;
            4'd5:  return f.c;
            4'd6:  return !f.z;
            4'd7:  return f.z;
            4'd8:  return !f.v;
            4'd9:  return f.v;
            4'd10: return !f.n;
            4'd11: return f.n;
            4'd12: return signed_ok;
            4'd13: return !signed_ok;
            4'd14: return signed_ok && !f.z;
            default: return f.z || !signed_ok;
        endcase
    endfunction

endpackage

// File: rtl/cond_eval.sv
module cond_eval
    import branch_pkg::*;
(
    input  logic [3:0] code,
    input  flags_t     flags,
    output logic       hit
);
    localparam int NUM_CODES = 16;

    logic [NUM_CODES-1:0] hold_vec;

    // One evaluator per code; the field then picks the lane.
    for (genvar i = 0; i < NUM_CODES; i++) begin : g_code
        assign hold_vec[i] = cond_holds(4'(i), flags);
    end

    assign hit = hold_vec[code];
endmodule

// File: rtl/loop_counter.sv
module loop_counter #(
    parameter int REG_W = 32,
    parameter int CNT_W = 16
) (
    input  logic [REG_W-1:0] cnt_in,
    output logic [REG_W-1:0] cnt_dec,
    output logic             wrapped
);
    localparam int HI_W = REG_W - CNT_W;

    logic [CNT_W-1:0] low_next;

    assign low_next = cnt_in[CNT_W-1:0] - 1'b1;
    assign wrapped  = (cnt_in[CNT_W-1:0] == '0);

    if (HI_W > 0) begin : g_upper
        assign cnt_dec = {cnt_in[REG_W-1:CNT_W], low_next};
    end else begin : g_flat
        assign cnt_dec = low_next;
    end
endmodule

// File: rtl/branch_decide_unit.sv
module branch_decide_unit
    import branch_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int REG_W  = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [11:0]       opcode_lo,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic              flag_v,
    input  logic              flag_c,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [15:0]       ext_word,
    input  logic [REG_W-1:0]  cnt_in,
    output logic              done,
    output logic [ADDR_W-1:0] next_pc,
    output logic [REG_W-1:0]  cnt_out,
    output logic              cnt_we,
    output logic [2:0]        cnt_sel,
    output logic [7:0]        set_byte,
    output logic [CYC_W-1:0]  cycles
);
    localparam int SHORT_W = 8;
    localparam int LONG_W  = 16;

    br_kind_e          kind;
    flags_t            flags;
    logic              hit;
    logic              short_form;
    logic [ADDR_W-1:0] short_off;
    logic [ADDR_W-1:0] long_off;
    logic [ADDR_W-1:0] pc_skip;
    logic [ADDR_W-1:0] pc_target;
    logic [REG_W-1:0]  cnt_dec;
    logic              wrapped;

    logic [ADDR_W-1:0] nx_pc;
    logic [REG_W-1:0]  nx_cnt;
    logic              nx_we;
    logic [7:0]        nx_byte;
    logic [CYC_W-1:0]  nx_cyc;

    assign kind  = br_kind_e'(req_kind);
    assign flags = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};

    cond_eval u_cond (
        .code  (opcode_lo[11:8]),
        .flags (flags),
        .hit   (hit)
    );

    loop_counter #(.REG_W(REG_W), .CNT_W(CNT_W)) u_loop (
        .cnt_in  (cnt_in),
        .cnt_dec (cnt_dec),
        .wrapped (wrapped)
    );

    assign short_form = (opcode_lo[SHORT_W-1:0] != '0);
    assign short_off  = {{(ADDR_W-SHORT_W){opcode_lo[SHORT_W-1]}}, opcode_lo[SHORT_W-1:0]};
    assign long_off   = {{(ADDR_W-LONG_W){ext_word[LONG_W-1]}}, ext_word};
    assign pc_skip    = cur_pc + ADDR_W'(2);
    assign pc_target  = cur_pc + (short_form ? short_off : long_off);

    always_comb begin
        nx_pc   = cur_pc;
        nx_cnt  = cnt_in;
        nx_we   = 1'b0;
        nx_byte = 8'h00;
        nx_cyc  = CYC_TAKEN;
        case (kind)
            KIND_BCOND: begin
                if (hit) begin
                    nx_pc  = pc_target;
                    nx_cyc = CYC_TAKEN;
                end else if (short_form) begin
                    nx_pc  = cur_pc;
                    nx_cyc = CYC_SKIP_SHORT;
                end else begin
                    nx_pc  = pc_skip;
                    nx_cyc = CYC_SKIP_LONG;
                end
            end
            KIND_BALWAYS: begin
                nx_pc  = pc_target;
                nx_cyc = CYC_TAKEN;
            end
            KIND_LOOP: begin
                if (hit) begin
                    nx_pc  = pc_skip;
                    nx_cyc = CYC_LOOP_HIT;
                end else begin
                    nx_we  = 1'b1;
                    nx_cnt = cnt_dec;
                    if (wrapped) begin
                        nx_pc  = pc_skip;
                        nx_cyc = CYC_LOOP_WRAP;
                    end else begin
                        nx_pc  = cur_pc + long_off;
                        nx_cyc = CYC_TAKEN;
                    end
                end
            end
            KIND_SETB: begin
                nx_pc   = cur_pc;
                nx_byte = hit ? 8'hFF : 8'h00;
                nx_cyc  = hit ? CYC_SET_TRUE : CYC_SET_FALSE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b0;
            cnt_we   <= 1'b0;
            next_pc  <= '0;
            cnt_out  <= '0;
            cnt_sel  <= '0;
            set_byte <= '0;
            cycles   <= '0;
        end else if (req_valid) begin
            done     <= 1'b1;
            cnt_we   <= nx_we;
            next_pc  <= nx_pc;
            cnt_out  <= nx_cnt;
            cnt_sel  <= opcode_lo[2:0];
            set_byte <= nx_byte;
            cycles   <= nx_cyc;
        end else begin
            done   <= 1'b0;
            cnt_we <= 1'b0;
        end
    end
endmodule

// File: rtl/branch_decide_chk.sv
module branch_decide_chk #(
    parameter int ADDR_W = 32,
    parameter int REG_W  = 32,
    parameter int CNT_W  = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    req_valid,
    input logic [1:0]              req_kind,
    input logic [ADDR_W-1:0]       cur_pc,
    input logic [REG_W-CNT_W-1:0]  cnt_in_hi,
    input logic                    done,
    input logic [ADDR_W-1:0]       next_pc,
    input logic [REG_W-1:0]        cnt_out,
    input logic                    cnt_we,
    input logic [7:0]              set_byte,
    input logic [4:0]              cycles
);
    assert_done_after_req_R9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> done);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!done && !cnt_we));

    assert_upper_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (done && cnt_we) |-> (cnt_out[REG_W-1:CNT_W] == $past(cnt_in_hi)));

    assert_wrap_exit_R7: assert property (@(posedge clk) disable iff (rst)
        (done && cnt_we && cycles == 5'd14) |->
            ((&cnt_out[CNT_W-1:0]) && next_pc == $past(cur_pc) + ADDR_W'(2)));

    assert_set_no_write_R8: assert property (@(posedge clk) disable iff (rst)
        (done && $past(req_kind) == 2'd3) |->
            (!cnt_we && next_pc == $past(cur_pc) && (set_byte == 8'hFF || set_byte == 8'h00)));

    assert_skip_short_R4: assert property (@(posedge clk) disable iff (rst)
        (done && cycles == 5'd8) |-> (next_pc == $past(cur_pc)));

    assert_loop_exit_R6: assert property (@(posedge clk) disable iff (rst)
        (done && $past(req_kind) == 2'd2 && cycles == 5'd12) |->
            (!cnt_we && next_pc == $past(cur_pc) + ADDR_W'(2)));

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (!done && !cnt_we));
endmodule

bind branch_decide_unit branch_decide_chk #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .cur_pc    (cur_pc),
    .cnt_in_hi (cnt_in[REG_W-1:CNT_W]),
    .done      (done),
    .next_pc   (next_pc),
    .cnt_out   (cnt_out),
    .cnt_we    (cnt_we),
    .set_byte  (set_byte),
    .cycles    (cycles)
);

// File: tb/sim_branch_decide_unit.sv
module sim_branch_decide_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [11:0] opcode_lo = '0;
    logic        flag_n = 1'b0, flag_z = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
    logic [31:0] cur_pc = '0;
    logic [15:0] ext_word = '0;
    logic [31:0] cnt_in = '0;
    logic        done;
    logic [31:0] next_pc;
    logic [31:0] cnt_out;
    logic        cnt_we;
    logic [2:0]  cnt_sel;
    logic [7:0]  set_byte;
    logic [4:0]  cycles;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    branch_decide_unit u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .opcode_lo(opcode_lo), .flag_n(flag_n), .flag_z(flag_z),
        .flag_v(flag_v), .flag_c(flag_c), .cur_pc(cur_pc),
        .ext_word(ext_word), .cnt_in(cnt_in), .done(done),
        .next_pc(next_pc), .cnt_out(cnt_out), .cnt_we(cnt_we),
        .cnt_sel(cnt_sel), .set_byte(set_byte), .cycles(cycles)
    );

    // Expected condition truth, written from the table in R1.
    function automatic logic ref_cond(input logic [3:0] code, input logic [3:0] f);
        logic n, z, v, c;
        {n, z, v, c} = f;
        case (code)
            4'h0: ref_cond = 1'b1;
            4'h1: ref_cond = 1'b0;
            4'h2: ref_cond = ~c & ~z;
            4'h3: ref_cond = c | z;
            4'h4: ref_cond = ~c;
            4'h5: ref_cond = c;
            4'h6: ref_cond = ~z;
            4'h7: ref_cond = z;
            4'h8: ref_cond = ~v;
            4'h9: ref_cond = v;
            4'hA: ref_cond = ~n;
            4'hB: ref_cond = n;
            4'hC: ref_cond = (n & v) | (~n & ~v);
            4'hD: ref_cond = (n & ~v) | (~n & v);
            4'hE: ref_cond = ((n & v) | (~n & ~v)) & ~z;
            default: ref_cond = z | (n & ~v) | (~n & v);
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Drive on a falling edge; on return the registered result is visible.
    task automatic issue(input logic [1:0] k, input logic [11:0] op, input logic [3:0] f,
                         input logic [31:0] pc, input logic [15:0] ext, input logic [31:0] cnt);
        @(negedge clk);
        req_kind = k; opcode_lo = op; {flag_n, flag_z, flag_v, flag_c} = f;
        cur_pc = pc; ext_word = ext; cnt_in = cnt; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        check(!done && !cnt_we && next_pc == 0 && cnt_out == 0 && set_byte == 0 && cycles == 0,
              "R10 reset state", {done, cnt_we, next_pc, cycles}, 64'd0);
    endtask

    task automatic t_cond_table();
        for (int code = 0; code < 16; code++) begin
            for (int f = 0; f < 16; f++) begin
                logic        t;
                logic [31:0] exp_pc;
                logic [4:0]  exp_cyc;
                t = ref_cond(4'(code), 4'(f));
                exp_pc  = t ? 32'h0000_0FF0 : 32'h0000_1000;
                exp_cyc = t ? 5'd10 : 5'd8;
                issue(2'd0, {4'(code), 8'hF0}, 4'(f), 32'h0000_1000, 16'h1234, 32'h0);
                check(done && next_pc == exp_pc && cycles == exp_cyc,
                      $sformatf("R1 R2 R4 code=%0d flags=%0d", code, f),
                      {27'd0, cycles, next_pc}, {27'd0, exp_cyc, exp_pc});
            end
        end
    endtask

    task automatic t_long_disp();
        issue(2'd0, 12'h700, 4'b0100, 32'h0002_0000, 16'h8000, 32'h0);
        check(next_pc == 32'h0001_8000 && cycles == 5'd10, "R3 long taken",
              {27'd0, cycles, next_pc}, {27'd10, 32'h0001_8000});
        issue(2'd0, 12'h700, 4'b0000, 32'h0002_0000, 16'h8000, 32'h0);
        check(next_pc == 32'h0002_0002 && cycles == 5'd12, "R4 long not taken",
              {27'd0, cycles, next_pc}, {27'd12, 32'h0002_0002});
    endtask

    task automatic t_always();
        issue(2'd1, 12'h17F, 4'b0000, 32'h0000_4000, 16'h0000, 32'h0);
        check(next_pc == 32'h0000_407F && cycles == 5'd10, "R5 short always",
              {27'd0, cycles, next_pc}, {27'd10, 32'h0000_407F});
        issue(2'd1, 12'h100, 4'b1111, 32'h0000_4000, 16'h0100, 32'h0);
        check(next_pc == 32'h0000_4100 && cycles == 5'd10, "R5 long always",
              {27'd0, cycles, next_pc}, {27'd10, 32'h0000_4100});
    endtask

    task automatic t_loop();
        issue(2'd2, 12'h605, 4'b0000, 32'h0000_2000, 16'hFFF0, 32'hABCD_0005);
        check(next_pc == 32'h0000_2002 && cycles == 5'd12 && !cnt_we, "R6 loop exit on condition",
              {26'd0, cnt_we, cycles, next_pc}, {26'd0, 1'b0, 5'd12, 32'h0000_2002});
        issue(2'd2, 12'h105, 4'b0000, 32'h0000_2000, 16'hFFF0, 32'hABCD_0005);
        check(cnt_we && cnt_sel == 3'd5 && cnt_out == 32'hABCD_0004, "R7 decrement",
              {28'd0, cnt_we, cnt_sel, cnt_out}, {28'd0, 1'b1, 3'd5, 32'hABCD_0004});
        check(next_pc == 32'h0000_1FF0 && cycles == 5'd10, "R7 loop branch",
              {27'd0, cycles, next_pc}, {27'd10, 32'h0000_1FF0});
        issue(2'd2, 12'h103, 4'b0000, 32'h0000_2000, 16'hFFF0, 32'h1234_0000);
        check(cnt_we && cnt_out == 32'h1234_FFFF && next_pc == 32'h0000_2002 && cycles == 5'd14,
              "R7 wrap exit", {27'd0, cycles, cnt_out}, {27'd14, 32'h1234_FFFF});
        issue(2'd2, 12'h100, 4'b0000, 32'h0000_2000, 16'h0010, 32'h0000_0001);
        check(cnt_we && cnt_out == 32'h0000_0000 && next_pc == 32'h0000_2010 && cycles == 5'd10,
              "R7 reaches zero and branches", {27'd0, cycles, next_pc}, {27'd10, 32'h0000_2010});
    endtask

    task automatic t_set();
        issue(2'd3, 12'h700, 4'b0100, 32'h0000_3000, 16'h0, 32'h0);
        check(set_byte == 8'hFF && cycles == 5'd6 && next_pc == 32'h0000_3000 && !cnt_we,
              "R8 set true", {19'd0, cycles, set_byte, next_pc}, {19'd0, 5'd6, 8'hFF, 32'h0000_3000});
        issue(2'd3, 12'h700, 4'b0000, 32'h0000_3000, 16'h0, 32'h0);
        check(set_byte == 8'h00 && cycles == 5'd4 && !cnt_we,
              "R8 set false", {51'd0, cycles, set_byte}, {51'd0, 5'd4, 8'h00});
    endtask

    task automatic t_strobe();
        issue(2'd2, 12'h102, 4'b0000, 32'h0000_5000, 16'h0020, 32'h0000_0009);
        check(done && cnt_we, "R9 strobe high", {62'd0, done, cnt_we}, 64'd3);
        @(negedge clk);
        check(!done && !cnt_we && next_pc == 32'h0000_5020, "R9 strobe drops, pc held",
              {30'd0, done, cnt_we, next_pc}, {32'd0, 32'h0000_5020});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R9 watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cond_table();
        t_long_disp();
        t_always();
        t_loop();
        t_set();
        t_strobe();
        finish_run();
    end
endmodule